// File: doc/BRIEF.md
# Windowed Nonvolatile Array Read Port

This block serves bus reads from a 4096-byte nonvolatile array. The storage is kept as 2048 words of 16 bits and sits in a fixed 4 KB address window starting at 0x1000. A read may ask for a single byte, an aligned 16-bit word or a misaligned 16-bit word. Byte and aligned-word reads finish in the cycle they are presented. A misaligned word straddles two physical words, so it is split over two cycles and the bus is stalled for the first one.

An array-enable input makes the array transparent. While it is low, the block claims no address, drives zero data and never stalls, so a lower-priority resource decoded at the same addresses can answer the read. The storage is a plain register array with a simple word load port that stands in for the cell contents. Any word that has not been loaded since reset reads as erased (all ones).

Control is a two-state machine. `ST_IDLE` serves one-cycle reads. On a misaligned hit it takes the transition *split start* to `ST_SPLIT`, capturing the word index, the first byte and a top-of-window flag. `ST_SPLIT` finishes the read from the captured values and always returns to `ST_IDLE` (*split finish*). In every other case `ST_IDLE` stays in `ST_IDLE` (*idle hold*).

Top module: `eep_read_port`

## Requirements
- R1: `rd_hit` is high in `ST_IDLE` exactly when `rd_req` is high, `array_en` is high and `rd_addr` lies in 0x1000..0x1FFF. While `rd_hit` is low, `rd_data` is 0, `rd_ready` is 1 and `rd_range_err` is 0.
- R2: A byte read (`rd_size`=0) returns the addressed byte on `rd_data[7:0]`, with `rd_data[15:8]`=0, in the same cycle with `rd_ready`=1. Byte order is big-endian: an even offset selects bits [15:8] of its word and an odd offset selects bits [7:0].
- R3: An aligned word read (`rd_size`=1, `rd_addr[0]`=0) returns the whole word in the same cycle with `rd_ready`=1.
- R4: A misaligned word read (`rd_size`=1, `rd_addr[0]`=1) holds `rd_ready` low for one cycle. In the next cycle `rd_ready` is 1 and `rd_data` is {byte A, byte A+1}.
- R5: During the second cycle of a misaligned read the result depends only on the address captured in the first cycle. `rd_hit` stays 1 whatever `rd_addr`, `rd_size`, `rd_req` and `array_en` do in that cycle.
- R6: After reset, every byte that has not been loaded reads 0xFF.
- R7: A misaligned word read at 0x1FFF returns 0xFF as its low byte and raises `rd_range_err` in its completion cycle. `rd_range_err` is 0 in every other cycle.
- R8: A word written through the load port (`cell_we`, `cell_widx`, `cell_wdata`) reads back from the next cycle on.
- R9: Out of reset the machine is in `ST_IDLE`: with no request, `rd_hit`=0 and `rd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| array_en | input | 1 | Array answers reads when high |
| rd_req | input | 1 | Read request |
| rd_addr | input | 16 | Byte address |
| rd_size | input | 1 | 0 = byte, 1 = 16-bit word |
| cell_we | input | 1 | Storage word load strobe |
| cell_widx | input | 11 | Word index for load |
| cell_wdata | input | 16 | Word value for load |
| rd_hit | output | 1 | Array claims the current read |
| rd_ready | output | 1 | Low while the bus must wait |
| rd_data | output | 16 | Read result (0 on a miss) |
| rd_range_err | output | 1 | Misaligned read ran off the top byte |

## Verification
The completion cycle of a split read and the decode of a fresh bus request can fall in the same cycle. In `ST_SPLIT` the bus inputs may already carry the next address, a different size or a cleared enable. The bench provokes this by scrambling `rd_addr`, `rd_size` and `array_en` in the completion cycle of randomly chosen misaligned reads. It judges the outcome against the bench's own byte model: data, hit and range flag must still belong to the captured address. The top-of-window case at 0x1FFF is driven both directly and with scrambled inputs.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } rd_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SPLIT = 1'b1
    } split_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/eep_addr_decode.sv
module eep_addr_decode #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h1000,
    parameter int                ARRAY_BYTES = 4096,
    localparam int               WORDS       = ARRAY_BYTES / 2,
    localparam int               IDX_W       = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [IDX_W-1:0]  widx,
    output logic              odd,
    output logic              last_word
);

    localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(ARRAY_BYTES);

    logic [ADDR_W:0] wide;
    logic [ADDR_W:0] ofs;

    always_comb begin
        wide      = {1'b0, addr};
        ofs       = wide - LO;
        in_win    = (wide >= LO) && (wide < HI);
        widx      = IDX_W'(ofs >> 1);
        odd       = ofs[0];
        last_word = (widx == IDX_W'(WORDS - 1));
    end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int  WORDS = 2048,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [15:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [15:0]      rdata
);

    logic [15:0]      cells [WORDS];
    logic [WORDS-1:0] filled;

    // Cell contents carry no reset: only the fill flags do.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (we) begin
            filled[widx] <= 1'b1;
        end
    end

    // A word never loaded since reset reads as erased.
    assign rdata = filled[ridx] ? cells[ridx] : {2{eep_pkg::ERASED_BYTE}};

endmodule

// File: rtl/eep_split_fsm.sv
module eep_split_fsm #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_hit,
    input  logic             req_word,
    input  logic             req_odd,
    input  logic             req_last,
    input  logic [IDX_W-1:0] req_widx,
    input  logic [15:0]      cur_word,
    output logic [IDX_W-1:0] fetch_idx,
    output logic             hit,
    output logic             ready,
    output logic [15:0]      data,
    output logic             range_err
);

    import eep_pkg::*;

    split_state_e     st_q, st_d;
    logic [IDX_W-1:0] held_idx;
    logic [7:0]       held_byte;
    logic             held_last;
    logic             capture;

    // State register and split capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            held_idx  <= '0;
            held_byte <= '0;
            held_last <= 1'b0;
        end else begin
            st_q <= st_d;
            if (capture) begin
                held_idx  <= req_widx;
                held_byte <= cur_word[7:0];
                held_last <= req_last;
            end
        end
    end

    // Outputs and next state.
    always_comb begin
        st_d      = st_q;
        capture   = 1'b0;
        fetch_idx = req_widx;
        hit       = 1'b0;
        ready     = 1'b1;
        data      = '0;
        range_err = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                fetch_idx = req_widx;
                hit       = req_hit;
                if (req_hit) begin
                    if (req_word && req_odd) begin
                        ready   = 1'b0;
                        capture = 1'b1;
                        st_d    = ST_SPLIT;
                    end else if (req_word) begin
                        data = cur_word;
                    end else begin
                        data = {8'h00, req_odd ? cur_word[7:0] : cur_word[15:8]};
                    end
                end
            end
            ST_SPLIT: begin
                fetch_idx = held_last ? '0 : held_idx + 1'b1;
                hit       = 1'b1;
                data      = {held_byte, held_last ? ERASED_BYTE : cur_word[15:8]};
                range_err = held_last;
                st_d      = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/eep_read_port.sv
module eep_read_port #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h1000,
    parameter int                ARRAY_BYTES = 4096,
    localparam int               WORDS       = ARRAY_BYTES / 2,
    localparam int               IDX_W       = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              array_en,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_size,
    input  logic              cell_we,
    input  logic [IDX_W-1:0]  cell_widx,
    input  logic [15:0]       cell_wdata,
    output logic              rd_hit,
    output logic              rd_ready,
    output logic [15:0]       rd_data,
    output logic              rd_range_err
);

    logic             in_win;
    logic [IDX_W-1:0] dec_widx;
    logic             dec_odd;
    logic             dec_last;
    logic [IDX_W-1:0] fetch_idx;
    logic [15:0]      fetch_word;
    logic             req_hit;
    logic             req_word;

    eep_addr_decode #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .ARRAY_BYTES (ARRAY_BYTES)
    ) u_dec (
        .addr      (rd_addr),
        .in_win    (in_win),
        .widx      (dec_widx),
        .odd       (dec_odd),
        .last_word (dec_last)
    );

    assign req_hit  = rd_req && array_en && in_win;
    assign req_word = (rd_size == eep_pkg::SZ_WORD);

    eep_store #(
        .WORDS (WORDS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cell_we),
        .widx  (cell_widx),
        .wdata (cell_wdata),
        .ridx  (fetch_idx),
        .rdata (fetch_word)
    );

    eep_split_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hit   (req_hit),
        .req_word  (req_word),
        .req_odd   (dec_odd),
        .req_last  (dec_last),
        .req_widx  (dec_widx),
        .cur_word  (fetch_word),
        .fetch_idx (fetch_idx),
        .hit       (rd_hit),
        .ready     (rd_ready),
        .data      (rd_data),
        .range_err (rd_range_err)
    );

endmodule

// File: rtl/eep_read_port_chk.sv
module eep_read_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        array_en,
    input logic        rd_req,
    input logic        rd_addr_lsb,
    input logic        rd_size,
    input logic        rd_hit,
    input logic        rd_ready,
    input logic [15:0] rd_data,
    input logic        rd_range_err
);

    logic in_split;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_split <= 1'b0;
        else        in_split <= !rd_ready;
    end

    // R1: a miss is silent on the bus
    a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == 16'h0000) && rd_ready && !rd_range_err);

    // R1: a stall happens only for a live, enabled request
    a_r1_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> rd_req && array_en && rd_hit);

    // R4 / R5: a stall lasts exactly one cycle and the following cycle still hits
    a_r4_one_cycle_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |=> rd_ready && rd_hit);

    // R2: byte reads leave the upper half zero
    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_split && rd_hit && rd_size == 1'b0) |-> rd_data[15:8] == 8'h00);

    // R3: aligned word reads never stall
    a_r3_aligned_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_split && rd_hit && rd_size == 1'b1 && !rd_addr_lsb) |-> rd_ready);

    // R7: range flag only in a split completion cycle, with an erased low byte
    a_r7_err_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
        rd_range_err |-> in_split && rd_hit && rd_ready && rd_data[7:0] == 8'hFF);

endmodule

bind eep_read_port eep_read_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .array_en     (array_en),
    .rd_req       (rd_req),
    .rd_addr_lsb  (rd_addr[0]),
    .rd_size      (rd_size),
    .rd_hit       (rd_hit),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .rd_range_err (rd_range_err)
);

// File: tb/eep_read_port_bench.sv
`timescale 1ns/1ps
module eep_read_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        array_en = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_size = 1'b0;
    logic        cell_we = 1'b0;
    logic [10:0] cell_widx = '0;
    logic [15:0] cell_wdata = '0;
    logic        rd_hit;
    logic        rd_ready;
    logic [15:0] rd_data;
    logic        rd_range_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model [2048];

    always #5 clk = ~clk;

    eep_read_port u_eep_read_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .array_en     (array_en),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_size      (rd_size),
        .cell_we      (cell_we),
        .cell_widx    (cell_widx),
        .cell_wdata   (cell_wdata),
        .rd_hit       (rd_hit),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .rd_range_err (rd_range_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (addr=%h)", tag, act, exp, rd_addr);
        end
    endtask

    function automatic bit in_window(logic [15:0] a);
        return (a >= 16'h1000) && (a <= 16'h1FFF);
    endfunction

    function automatic logic [7:0] exp_byte(logic [16:0] a);
        logic [15:0] w;
        if (a < 17'h1000 || a > 17'h1FFF) return 8'hFF;
        w = model[11'((a - 17'h1000) >> 1)];
        return a[0] ? w[7:0] : w[15:8];
    endfunction

    task automatic model_erase();
        for (int i = 0; i < 2048; i++) model[i] = 16'hFFFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_req = 1'b0;
        cell_we = 1'b0;
        model_erase();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_word(logic [10:0] idx, logic [15:0] val);
        @(negedge clk);
        cell_we = 1'b1;
        cell_widx = idx;
        cell_wdata = val;
        model[idx] = val;
        @(posedge clk);
        #1 cell_we = 1'b0;
    endtask

    task automatic do_read(logic [15:0] a, logic sz, logic en, bit scramble);
        bit          hit_e;
        logic [15:0] w;
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = a;
        rd_size = sz;
        array_en = en;
        #1;
        hit_e = en && in_window(a);
        chk("R1 hit", {31'd0, rd_hit}, {31'd0, hit_e});
        if (!hit_e) begin
            chk("R1 miss data", {16'd0, rd_data}, 32'd0);
            chk("R1 miss ready", {31'd0, rd_ready}, 32'd1);
        end else if (sz == 1'b0) begin
            chk("R2 byte data", {16'd0, rd_data}, {24'd0, exp_byte({1'b0, a})});
            chk("R2 byte ready", {31'd0, rd_ready}, 32'd1);
        end else if (!a[0]) begin
            w = {exp_byte({1'b0, a}), exp_byte({1'b0, a} + 17'd1)};
            chk("R3 word data", {16'd0, rd_data}, {16'd0, w});
            chk("R3 word ready", {31'd0, rd_ready}, 32'd1);
        end else begin
            chk("R4 stall", {31'd0, rd_ready}, 32'd0);
            @(negedge clk);
            if (scramble) begin
                rd_addr = 16'($urandom);
                rd_size = 1'($urandom);
                array_en = 1'($urandom);
                rd_req = 1'($urandom);
            end
            #1;
            w = {exp_byte({1'b0, a}), exp_byte({1'b0, a} + 17'd1)};
            chk("R4 split ready", {31'd0, rd_ready}, 32'd1);
            chk("R4 split data", {16'd0, rd_data}, {16'd0, w});
            chk("R5 split hit", {31'd0, rd_hit}, 32'd1);
            chk("R7 range flag", {31'd0, rd_range_err}, {31'd0, a == 16'h1FFF});
        end
        if (!(hit_e && sz && a[0])) chk("R7 no flag", {31'd0, rd_range_err}, 32'd0);
        rd_req = 1'b0;
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd2024));
        model_erase();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9 idle hit", {31'd0, rd_hit}, 32'd0);
        chk("R9 idle ready", {31'd0, rd_ready}, 32'd1);
        // R6: erased after reset
        do_read(16'h1000, 1'b1, 1'b1, 1'b0);
        do_read(16'h1733, 1'b0, 1'b1, 1'b0);
        do_read(16'h1555, 1'b1, 1'b1, 1'b0);
        // R8: load then read next cycle
        load_word(11'd0, 16'hA1B2);
        do_read(16'h1000, 1'b1, 1'b1, 1'b0);
        load_word(11'd1, 16'hC3D4);
        load_word(11'd2047, 16'h5E6F);
        load_word(11'd2046, 16'h7788);
        // R2 byte order, R4 misaligned, R7 top byte
        do_read(16'h1000, 1'b0, 1'b1, 1'b0);
        do_read(16'h1001, 1'b0, 1'b1, 1'b0);
        do_read(16'h1001, 1'b1, 1'b1, 1'b0);
        do_read(16'h1FFE, 1'b1, 1'b1, 1'b0);
        do_read(16'h1FFD, 1'b1, 1'b1, 1'b0);
        do_read(16'h1FFF, 1'b1, 1'b1, 1'b0);
        do_read(16'h1FFF, 1'b1, 1'b1, 1'b1);
        do_read(16'h1FFF, 1'b0, 1'b1, 1'b0);
        // R1 window edges and disabled array
        do_read(16'h0FFF, 1'b1, 1'b1, 1'b0);
        do_read(16'h2000, 1'b0, 1'b1, 1'b0);
        do_read(16'h1001, 1'b1, 1'b0, 1'b0);
        do_read(16'h1000, 1'b1, 1'b0, 1'b0);
        // Random mix
        for (int i = 0; i < 300; i++) load_word(11'($urandom), 16'($urandom));
        for (int i = 0; i < 700; i++) begin
            logic [15:0] a;
            a = ($urandom % 8 == 0) ? 16'($urandom) : 16'h1000 + 16'($urandom % 4096);
            do_read(a, 1'($urandom), ($urandom % 6) != 0, 1'($urandom));
        end
        // R6: reset erases previously loaded words
        do_reset();
        #1;
        chk("R9 ready after reset", {31'd0, rd_ready}, 32'd1);
        do_read(16'h1000, 1'b1, 1'b1, 1'b0);
        do_read(16'h1FFE, 1'b1, 1'b1, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule